// File: doc/BRIEF.md
# Receiver Blanking and No-Response Timer

This block gates a contactless reader's receive path after each transmission. Two down-counters share one timebase enable, `tick`, which pulses once per 9.44 µs period. The first is the blanking timer. When transmission ends it holds the receive decoder disabled until a programmed number of ticks has passed, so transients from the transmitter are not decoded. The second is the no-response timer. It starts when an anticollision slot opens. If no tag frame start arrives before its programmed count runs out, it raises an interrupt flag, which tells the host that the next slot can be opened.

Both durations are 8-bit register values counted in ticks. The blanking value can be written directly. Any write of the protocol selection also overwrites it with a minimum response time that depends on the protocol family. A pulse on `tx_end` or `slot_start` always starts the matching timer over from the value its register holds at that moment.

Top module: `rx_gate_timer`

## Requirements
- R1: After reset `rx_en` is 1, `noresp_irq` is 0, the blanking register holds 0x1F and the no-response register holds 0x0E.
- R2: A `tx_end` pulse with a blanking value N > 0 drives `rx_en` low from the next cycle on. `rx_en` returns high in the cycle after the clock edge that samples the N-th `tick`.
- R3: A `tx_end` pulse with a blanking value of 0 leaves `rx_en` high.
- R4: A `proto_wr` pulse loads the blanking register from `proto_sel[4:2]`: 000 or 001 give 0x1F, 010 gives 0x0E, 011 gives 0x1A, 110 gives 0x20, and any other code gives 0x1F. When `proto_wr` and `wr_wait` occur in the same cycle, `proto_wr` wins.
- R5: A `slot_start` pulse with a no-response value N > 0 sets `noresp_irq` in the cycle after the edge that samples the N-th `tick`, unless the timer was stopped first.
- R6: An `rx_sof` pulse while the no-response timer runs stops the timer without setting the flag. This includes an `rx_sof` in the same cycle as the final tick.
- R7: A `slot_start` pulse with a no-response value of 0 sets `noresp_irq` in the next cycle.
- R8: A new `tx_end` or `slot_start` restarts its timer from the current register value and discards the ticks already counted. `slot_start` also clears `noresp_irq`.
- R9: `rx_en` changes only on a cycle that samples `tick` or `tx_end`. A `tick` while no timer runs has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per 9.44 µs unit |
| tx_end | input | 1 | Pulse at the end of transmission |
| slot_start | input | 1 | Pulse when an anticollision slot opens |
| rx_sof | input | 1 | Pulse when a tag frame start is detected |
| wr_wait | input | 1 | Write strobe for the blanking register |
| wr_noresp | input | 1 | Write strobe for the no-response register |
| wr_data | input | 8 | Data for both register writes |
| proto_wr | input | 1 | Protocol-selection write strobe |
| proto_sel | input | 5 | Protocol code written with `proto_wr` |
| rx_en | output | 1 | High when the receive decoder may run |
| noresp_irq | output | 1 | No-response interrupt flag |

## Verification
Every output is registered once, so each result is due one clock after the edge that samples its cause. `rx_en` falls in the cycle after `tx_end`, and it rises, or `noresp_irq` sets, in the cycle after the edge that samples the final `tick`. The bench drives each pulse for exactly one cycle on a falling edge. It reads the outputs at the following falling edge, after the edge that consumed the pulse. To test the boundary, it applies one tick fewer than the count and checks that nothing has changed yet, then applies the last tick and checks that the output flips.

// File: rtl/rx_gate_timer.sv
module rx_gate_timer #(
  parameter int          W        = 8,
  parameter logic [W-1:0] WAIT_RST = 8'h1F,
  parameter logic [W-1:0] NR_RST   = 8'h0E
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         tx_end,
  input  logic         slot_start,
  input  logic         rx_sof,
  input  logic         wr_wait,
  input  logic         wr_noresp,
  input  logic [W-1:0] wr_data,
  input  logic         proto_wr,
  input  logic [4:0]   proto_sel,
  output logic         rx_en,
  output logic         noresp_irq
);
  logic [W-1:0] wait_q, nr_q, wait_cnt, nr_cnt;
  logic         wait_run, nr_run;

  function automatic logic [W-1:0] proto_wait(input logic [4:0] p);
    case (p[4:2])
      3'b000, 3'b001: proto_wait = W'(8'h1F);
      3'b010:         proto_wait = W'(8'h0E);
      3'b011:         proto_wait = W'(8'h1A);
      3'b110:         proto_wait = W'(8'h20);
      default:        proto_wait = W'(8'h1F);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= WAIT_RST;
      nr_q   <= NR_RST;
    end else begin
      if (proto_wr)     wait_q <= proto_wait(proto_sel);
      else if (wr_wait) wait_q <= wr_data;
      if (wr_noresp)    nr_q   <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_run <= 1'b0;
      wait_cnt <= '0;
    end else if (tx_end) begin
      wait_run <= (wait_q != '0);
      wait_cnt <= wait_q;
    end else if (wait_run && tick) begin
      wait_cnt <= wait_cnt - 1'b1;
      if (wait_cnt == W'(1)) wait_run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nr_run     <= 1'b0;
      nr_cnt     <= '0;
      noresp_irq <= 1'b0;
    end else if (slot_start) begin
      nr_run     <= (nr_q != '0);
      nr_cnt     <= nr_q;
      noresp_irq <= (nr_q == '0);
    end else if (nr_run && rx_sof) begin
      nr_run <= 1'b0;
    end else if (nr_run && tick) begin
      nr_cnt <= nr_cnt - 1'b1;
      if (nr_cnt == W'(1)) begin
        nr_run     <= 1'b0;
        noresp_irq <= 1'b1;
      end
    end
  end

  assign rx_en = ~wait_run;

  // R2
  blank_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && wait_q != '0) |=> !rx_en);

  // R9
  rx_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !tx_end) |=> $stable(rx_en));

  // R6
  sof_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_run && rx_sof && !slot_start) |=> (!noresp_irq && !nr_run));

  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noresp_irq) |-> $past(slot_start || (nr_run && tick)));

  // R8
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && nr_q != '0) |=> !noresp_irq);
endmodule

// File: tb/test_rx_gate_timer.sv
module test_rx_gate_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, tx_end = 0, slot_start = 0, rx_sof = 0;
  logic wr_wait = 0, wr_noresp = 0, proto_wr = 0;
  logic [7:0] wr_data = '0;
  logic [4:0] proto_sel = '0;
  logic rx_en, noresp_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_gate_timer i_rx_gate_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_end(tx_end),
    .slot_start(slot_start), .rx_sof(rx_sof), .wr_wait(wr_wait),
    .wr_noresp(wr_noresp), .wr_data(wr_data), .proto_wr(proto_wr),
    .proto_sel(proto_sel), .rx_en(rx_en), .noresp_irq(noresp_irq));

  // {proto write?, data, ticks until rx_en returns}
  localparam logic [16:0] VEC [0:7] = '{
    {1'b1, 8'h08, 8'd14}, {1'b1, 8'h0C, 8'd26}, {1'b1, 8'h1A, 8'd32},
    {1'b1, 8'h02, 8'd31}, {1'b0, 8'h01, 8'd1},  {1'b0, 8'h05, 8'd5},
    {1'b0, 8'h00, 8'd0},  {1'b1, 8'h13, 8'd31}};

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic pulse_tx();    @(negedge clk) tx_end = 1;     @(negedge clk) tx_end = 0;     endtask
  task automatic pulse_slot();  @(negedge clk) slot_start = 1; @(negedge clk) slot_start = 0; endtask
  task automatic pulse_sof();   @(negedge clk) rx_sof = 1;     @(negedge clk) rx_sof = 0;     endtask
  task automatic write_wait(input logic [7:0] d);
    @(negedge clk) begin wr_wait = 1; wr_data = d; end
    @(negedge clk) wr_wait = 0;
  endtask
  task automatic write_nr(input logic [7:0] d);
    @(negedge clk) begin wr_noresp = 1; wr_data = d; end
    @(negedge clk) wr_noresp = 0;
  endtask
  task automatic write_proto(input logic [4:0] p);
    @(negedge clk) begin proto_wr = 1; proto_sel = p; end
    @(negedge clk) proto_wr = 0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rx_en, 1'b1, "R1 rx_en reset");
    chk(noresp_irq, 1'b0, "R1 irq reset");
    // R1 reset default 0x1F
    pulse_tx();
    chk(rx_en, 1'b0, "R1 R2 blank start");
    ticks(30); chk(rx_en, 1'b0, "R1 default 0x1F before");
    ticks(1);  chk(rx_en, 1'b1, "R1 default 0x1F expiry");
    // R9 idle ticks have no effect
    ticks(3); chk(rx_en, 1'b1, "R9 idle tick"); chk(noresp_irq, 1'b0, "R9 idle tick irq");

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][16]) write_proto(VEC[v][12:8]);
      else write_wait(VEC[v][15:8]);
      pulse_tx();
      if (VEC[v][7:0] == 0) chk(rx_en, 1'b1, "R3 zero wait");
      else begin
        ticks(int'(VEC[v][7:0]) - 1);
        chk(rx_en, 1'b0, VEC[v][16] ? "R4 reload before" : "R2 before expiry");
        ticks(1);
        chk(rx_en, 1'b1, VEC[v][16] ? "R4 reload expiry" : "R2 expiry");
      end
    end

    // R4 proto_wr wins over wr_wait
    @(negedge clk) begin proto_wr = 1; proto_sel = 5'h08; wr_wait = 1; wr_data = 8'h02; end
    @(negedge clk) begin proto_wr = 0; wr_wait = 0; end
    pulse_tx(); ticks(2); chk(rx_en, 1'b0, "R4 priority");
    ticks(12); chk(rx_en, 1'b1, "R4 priority expiry");

    // R1 no-response default 0x0E
    pulse_slot(); ticks(13); chk(noresp_irq, 1'b0, "R1 nr default before");
    ticks(1); chk(noresp_irq, 1'b1, "R1 R5 nr default flag");
    // R5
    write_nr(8'd3);
    pulse_slot(); chk(noresp_irq, 1'b0, "R8 slot clears flag");
    ticks(2); chk(noresp_irq, 1'b0, "R5 before expiry");
    ticks(1); chk(noresp_irq, 1'b1, "R5 expiry");
    // R6
    pulse_slot(); ticks(1); pulse_sof(); ticks(5);
    chk(noresp_irq, 1'b0, "R6 sof stops");
    pulse_slot(); ticks(2);
    @(negedge clk) begin tick = 1; rx_sof = 1; end
    @(negedge clk) begin tick = 0; rx_sof = 0; end
    ticks(2); chk(noresp_irq, 1'b0, "R6 sof on final tick");
    // R7
    write_nr(8'd0); pulse_slot(); chk(noresp_irq, 1'b1, "R7 zero immediate");
    // R8 restarts
    write_nr(8'd3); pulse_slot(); ticks(2); pulse_slot(); ticks(2);
    chk(noresp_irq, 1'b0, "R8 slot restart");
    ticks(1); chk(noresp_irq, 1'b1, "R8 slot restart expiry");
    write_wait(8'd4); pulse_tx(); ticks(3); pulse_tx(); ticks(3);
    chk(rx_en, 1'b0, "R8 tx restart");
    ticks(1); chk(rx_en, 1'b1, "R8 tx restart expiry");
    // R9 no change without tick
    pulse_tx(); repeat (10) @(negedge clk);
    chk(rx_en, 1'b0, "R9 hold without tick");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule